// File: doc/BRIEF.md
# Two-Wire Memory Slave Engine

This block is the slave side of a two-wire serial bus (clock and data lines, open-drain) in front of a 256-byte memory. It watches already-synchronized SCL and SDA samples and finds start and stop conditions. It shifts in the address byte and compares it against a fixed four-bit type code followed by three strap pins. It then acknowledges and runs byte writes, page writes, current-address reads, random reads and sequential reads. The engine never drives SDA high. Its only output to the line is a pull-low enable, which the pad turns into an open-drain driver.

The memory array sits outside the block and is reached through two valid/ready ports. On the write port a request stays valid, with stable address and data, until ready is seen high. The memory has to accept it within one byte time on the bus, which is nine SCL periods. On the read port the engine holds valid and the address until ready. The read data is taken in the cycle in which valid and ready are both high, so the memory returns it combinationally in that cycle. That handshake has to finish before the SCL falling edge on which the byte's first bit is driven. Back-pressure on either port stretches nothing on the bus. The bus master sets all bus timing. A write-busy input, driven by the external write timer, keeps the engine silent while a write cycle is in progress.

Top module: `twowire_mem_slave`

## Requirements
- R1: The engine ignores the bus until it sees a start condition (SDA falling while SCL is high). A stop condition (SDA rising while SCL is high) returns it to idle with SDA released. A start in any state, repeated starts included, restarts address reception.
- R2: The address byte is received MSB first: type code 1010 in bits 7..4, the strap pins in bits 3..1 (strap bit 2 in byte bit 3), and read/write in bit 0, where 1 means read. When it matches and busy is low, the engine pulls SDA low for the whole ninth SCL clock.
- R3: When the type code or strap field does not match, the engine does not acknowledge. It keeps SDA released for all further clocks until the next start.
- R4: While busy is high, a matching address byte is not acknowledged and the engine goes idle.
- R5: In a write transfer, the first byte after the address is the word address and loads the address counter. Every later byte is a data byte, posted on the write port with the current counter value. The word-address byte and every data byte are acknowledged.
- R6: After each written data byte, only the two low bits of the address counter increment, wrapping inside a four-byte page. The upper six bits stay unchanged, so a fifth data byte overwrites the page's first written location.
- R7: A read header with no preceding word address returns the byte at the address counter. The counter points one past the last location read or written.
- R8: A write header plus word address, followed by a repeated start and a read header, returns the byte at that word address.
- R9: When the master acknowledges a read byte, the engine sends the next byte. The read address increments across all eight bits, wrapping from 255 to 0.
- R10: A master non-acknowledge in the ninth clock of a read byte ends transmission. SDA stays released until the next start.
- R11: The SDA pull enable changes only while SCL is low. Read data bits are driven after SCL falls and sampled by the master on SCL rising.
- R12: A write-port or read-port request holds valid, address and data stable until ready is seen high. A read handshake completes before the first bit of its byte is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized serial clock sample |
| sda_i | input | 1 | Synchronized serial data line sample |
| strap_i | input | 3 | Device select strap pins |
| busy_i | input | 1 | Write cycle in progress; suppresses acknowledge |
| sda_pull_o | output | 1 | Pull SDA low when 1, release when 0 |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Memory accepts write |
| wr_addr_o | output | 8 | Write word address |
| wr_data_o | output | 8 | Write data byte |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Memory read data present this cycle |
| rd_addr_o | output | 8 | Read word address |
| rd_data_i | input | 8 | Read data, taken during the handshake |

## Verification
A wrong bit count or a wrong state shows on the bus within one byte. Either an acknowledge lands in the wrong clock, or a read byte arrives shifted, which the master sees as a wrong value in its very next byte. A wrong address counter is invisible during writes. It appears at the first later current-address or sequential read, and a page-wrap fault appears only when a page write runs past four bytes. A faulty address compare or busy gating appears as an acknowledge bit with the wrong polarity in the ninth clock of the header, so sweeping every strap and type value exposes it at once.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK,
    ST_WADR,
    ST_WDAT,
    ST_TX,
    ST_MACK
  } tw_state_e;

  typedef enum logic [1:0] {
    NX_WADR,
    NX_WDAT,
    NX_TX
  } tw_next_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/tw_bus_sense.sv
module tw_bus_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

  // R1: a start or stop condition is never seen on an SCL edge
  p_cond_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |-> (scl_i && $past(scl_i)));
endmodule

// File: rtl/tw_word_ctr.sv
module tw_word_ctr #(
  parameter int AW        = 8,
  parameter int PAGE_BITS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_val,
  input  logic          inc_page,
  input  logic          inc_full,
  output logic [AW-1:0] ctr_o
);
  localparam logic [AW-1:0] FULL_ONE = 1;

  logic [AW-1:0] ctr_q, page_nx, full_nx;

  assign full_nx = ctr_q + FULL_ONE;

  generate
    if (PAGE_BITS >= AW) begin : g_flat
      assign page_nx = full_nx;
    end else begin : g_paged
      localparam logic [PAGE_BITS-1:0] LO_ONE = 1;
      logic [PAGE_BITS-1:0] lo_nx;
      assign lo_nx   = ctr_q[PAGE_BITS-1:0] + LO_ONE;
      assign page_nx = {ctr_q[AW-1:PAGE_BITS], lo_nx};

      // R6: a page step never touches the page number
      p_page_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_page && !ld_en) |=> (ctr_o[AW-1:PAGE_BITS] == $past(ctr_o[AW-1:PAGE_BITS])));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        ctr_q <= '0;
    else if (ld_en)    ctr_q <= ld_val;
    else if (inc_page) ctr_q <= page_nx;
    else if (inc_full) ctr_q <= full_nx;
  end

  assign ctr_o = ctr_q;

  // R9: a read step moves the counter by exactly one, modulo the space
  p_full_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_full && !ld_en && !inc_page) |=> (ctr_o == $past(ctr_o) + FULL_ONE));
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
  parameter int AW        = 8,
  parameter int PAGE_BITS = 2,
  parameter int STRAP_W   = 3,
  parameter logic [6-STRAP_W:0] TYPE_CODE = 'b1010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               busy_i,
  output logic               sda_pull_o,
  output logic               wr_valid_o,
  input  logic               wr_ready_i,
  output logic [AW-1:0]      wr_addr_o,
  output logic [7:0]         wr_data_o,
  output logic               rd_valid_o,
  input  logic               rd_ready_i,
  output logic [AW-1:0]      rd_addr_o,
  input  logic [7:0]         rd_data_i
);
  import tw_pkg::*;

  localparam int TYPE_W = tw_pkg::BYTE_W - 1 - STRAP_W;

  logic scl_rise, scl_fall, start_det, stop_det;
  tw_state_e state;
  tw_next_e  nxt;
  logic [2:0] cnt;
  logic [1:0] ph;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic [7:0] byte_in;
  logic       pull_q;
  logic       rx_state, byte_done, hdr_match;
  logic       ld_en, inc_page, inc_full;
  logic [AW-1:0] ctr;

  tw_bus_sense u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  assign byte_in   = {rx_sh, sda_i};
  assign rx_state  = (state == ST_DEV) || (state == ST_WADR) || (state == ST_WDAT);
  assign byte_done = rx_state && scl_rise && (cnt == 3'd7) && !start_det && !stop_det;
  assign hdr_match = (byte_in[7:STRAP_W+1] == TYPE_CODE) && (byte_in[STRAP_W:1] == strap_i);

  assign ld_en    = byte_done && (state == ST_WADR);
  assign inc_page = byte_done && (state == ST_WDAT);
  assign inc_full = rd_valid_o && rd_ready_i;

  tw_word_ctr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (ld_en),
    .ld_val   (byte_in[AW-1:0]),
    .inc_page (inc_page),
    .inc_full (inc_full),
    .ctr_o    (ctr)
  );

  // Memory-side handshakes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      if (wr_valid_o && wr_ready_i) wr_valid_o <= 1'b0;
      if (inc_page) begin
        wr_valid_o <= 1'b1;
        wr_addr_o  <= ctr;
        wr_data_o  <= byte_in;
      end
    end
  end

  // Protocol sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      nxt        <= NX_WADR;
      cnt        <= '0;
      ph         <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      pull_q     <= 1'b0;
      rd_valid_o <= 1'b0;
    end else begin
      if (inc_full) begin
        rd_valid_o <= 1'b0;
        tx_sh      <= rd_data_i;
      end
      if (start_det) begin
        state  <= ST_DEV;
        cnt    <= '0;
        ph     <= '0;
        pull_q <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        ph     <= '0;
        pull_q <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_WADR, ST_WDAT: begin
            if (scl_rise) begin
              rx_sh <= byte_in[6:0];
              cnt   <= cnt + 3'd1;
            end
            if (byte_done) begin
              ph <= '0;
              if (state == ST_DEV) begin
                if (hdr_match && !busy_i) begin
                  state <= ST_ACK;
                  if (byte_in[0]) begin
                    nxt        <= NX_TX;
                    rd_valid_o <= 1'b1;
                  end else begin
                    nxt <= NX_WADR;
                  end
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                state <= ST_ACK;
                nxt   <= NX_WDAT;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (ph == 2'd0) begin
                pull_q <= 1'b1;
                ph     <= 2'd1;
              end else begin
                ph  <= '0;
                cnt <= '0;
                case (nxt)
                  NX_TX: begin
                    state  <= ST_TX;
                    pull_q <= ~tx_sh[7];
                  end
                  NX_WADR: begin
                    state  <= ST_WADR;
                    pull_q <= 1'b0;
                  end
                  default: begin
                    state  <= ST_WDAT;
                    pull_q <= 1'b0;
                  end
                endcase
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              pull_q <= ~tx_sh[6];
            end
            if (scl_rise) begin
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                state <= ST_MACK;
                ph    <= '0;
              end
            end
          end
          ST_MACK: begin
            if (ph == 2'd0 && scl_fall) begin
              pull_q <= 1'b0;
              ph     <= 2'd1;
            end else if (ph == 2'd1 && scl_rise) begin
              if (!sda_i) begin
                rd_valid_o <= 1'b1;
                ph         <= 2'd2;
              end else begin
                state <= ST_IDLE;
                ph    <= '0;
              end
            end else if (ph == 2'd2 && scl_fall) begin
              state  <= ST_TX;
              pull_q <= ~tx_sh[7];
              cnt    <= '0;
              ph     <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign rd_addr_o  = ctr;

  // R1: a start always restarts address reception from bit zero
  p_start_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_DEV && cnt == 3'd0 && !sda_pull_o));

  // R3 / R10: idle means released
  p_idle_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull_o);

  // R4: a header seen while busy leads straight to idle
  p_busy_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state == ST_DEV && busy_i) |=> (state == ST_IDLE));

  // R11: the pull enable moves only after SCL was seen low
  p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_i));

  // R12: write request held stable under back-pressure
  p_wr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  // R12: read request held stable under back-pressure
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));

  // R12: read data present before the first bit goes out
  p_rd_in_time_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && !start_det && ((state == ST_ACK && ph == 2'd1 && nxt == NX_TX) ||
                 (state == ST_MACK && ph == 2'd2))) |-> !rd_valid_o);
endmodule

// File: tb/twowire_mem_slave_tb.sv
module twowire_mem_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 3;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'd5;
  logic       busy = 1'b0;
  logic       sda_pull;
  wire        sda_line = sda_m & ~sda_pull;
  logic       wr_valid, wr_ready, rd_valid, rd_ready;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ctr;
  logic [3:0] cyc = '0;
  int n_chk = 0, n_bad = 0, mon_bad = 0;
  bit done = 1'b0;
  logic pull_prev = 1'b0, scl_prev = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  twowire_mem_slave u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .strap_i    (strap),
    .busy_i     (busy),
    .sda_pull_o (sda_pull),
    .wr_valid_o (wr_valid),
    .wr_ready_i (wr_ready),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .rd_valid_o (rd_valid),
    .rd_ready_i (rd_ready),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data)
  );

  // Memory model with back-pressure
  always @(posedge clk) cyc <= cyc + 4'd1;
  assign wr_ready = cyc[1];
  assign rd_ready = cyc[0];
  assign rd_data  = mem[rd_addr];
  always @(posedge clk) if (wr_valid && wr_ready) mem[wr_addr] <= wr_data;

  // R11 monitor: pull enable must not change across a high SCL interval
  always @(posedge clk) begin
    if (rst_n && scl_prev && scl_m && (sda_pull != pull_prev)) begin
      mon_bad++;
      $display("FAIL R11 pull changed while SCL high act=%0d exp=%0d", sda_pull, pull_prev);
    end
    pull_prev <= sda_pull;
    scl_prev  <= scl_m;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] hdr(input logic [2:0] dev, input logic rw);
    return {4'b1010, dev, rw};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(2*Q);
  endtask

  task automatic bit_out(input logic b);
    wt(Q);
    sda_m = b; wt(Q);
    scl_m = 1'b1; wt(2*Q);
    scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wt(Q);
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    b = sda_line; wt(Q);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(s);
    acked = !s;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_in(s);
      v[i] = s;
    end
    bit_out(!give_ack);
  endtask

  // Random read prologue: write header, word address, repeated start, read header
  task automatic seek_read(input logic [7:0] a);
    logic k;
    bus_start();
    send_byte(hdr(3'd5, 1'b0), k); chk("R8 write header ack", k, 1);
    send_byte(a, k);               chk("R8 word address ack", k, 1);
    bus_start();
    send_byte(hdr(3'd5, 1'b1), k); chk("R8 read header ack", k, 1);
    exp_ctr = a;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", WATCHDOG, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic k;
    logic [7:0] v, a;
    exp_ctr = 8'd0;
    wt(5);
    rst_n = 1'b1;
    wt(2);

    // Reset state (R1)
    chk("R1 reset pull", sda_pull, 0);
    chk("R1 reset wr_valid", wr_valid, 0);
    chk("R1 reset rd_valid", rd_valid, 0);

    // R1: a matching header with no start is ignored
    scl_m = 1'b0;
    send_byte(hdr(3'd5, 1'b0), k);
    chk("R1 no start no ack", k, 0);

    // R2 / R3: strap sweep
    for (int d = 0; d < 8; d++) begin
      bus_start();
      send_byte(hdr(3'(d), 1'b0), k);
      chk("R2 strap compare ack", k, (d == 5) ? 1 : 0);
      if (d != 5) begin
        send_byte(8'h00, k);
        chk("R3 silent after mismatch", k, 0);
      end
      bus_stop();
    end

    // R3: type code sweep
    for (int t = 0; t < 16; t++) begin
      if (t != 10) begin
        bus_start();
        send_byte({4'(t), 3'd5, 1'b1}, k);
        chk("R3 type code mismatch", k, 0);
        bus_stop();
      end
    end

    // R4: busy suppresses acknowledge, then recovery
    busy = 1'b1;
    bus_start();
    send_byte(hdr(3'd5, 1'b0), k);
    chk("R4 busy no ack", k, 0);
    send_byte(8'h10, k);
    chk("R4 busy stays silent", k, 0);
    bus_stop();
    busy = 1'b0;
    bus_start();
    send_byte(hdr(3'd5, 1'b0), k);
    chk("R4 ack after busy drops", k, 1);
    bus_stop();

    // R5: fill all pages with four-byte page writes
    for (int p = 0; p < 64; p++) begin
      bus_start();
      send_byte(hdr(3'd5, 1'b0), k); chk("R5 header ack", k, 1);
      send_byte(8'(p * 4), k);       chk("R5 word address ack", k, 1);
      for (int j = 0; j < 4; j++) begin
        send_byte(pat(p * 4 + j), k);
        chk("R5 data ack", k, 1);
        exp_mem[p * 4 + j] = pat(p * 4 + j);
      end
      bus_stop();
      exp_ctr = 8'(p * 4 + 4 - 4) + 8'd0;
      exp_ctr = {exp_ctr[7:2], 2'b00};
    end
    wt(4);

    // R6: six bytes from 0x21 wrap inside page 0x20..0x23
    a = 8'h21;
    bus_start();
    send_byte(hdr(3'd5, 1'b0), k); chk("R6 header ack", k, 1);
    send_byte(a, k);               chk("R6 word address ack", k, 1);
    for (int j = 0; j < 6; j++) begin
      send_byte(8'hC0 + 8'(j), k);
      chk("R6 data ack", k, 1);
      exp_mem[a] = 8'hC0 + 8'(j);
      a = {a[7:2], a[1:0] + 2'd1};
    end
    bus_stop();
    exp_ctr = a;
    wt(4);
    for (int i = 0; i < 256; i++) chk("R5 memory contents", mem[i], exp_mem[i]);

    // R7: two current-address reads following the page write
    for (int r = 0; r < 2; r++) begin
      bus_start();
      send_byte(hdr(3'd5, 1'b1), k); chk("R7 read header ack", k, 1);
      recv_byte(v, 1'b0);
      chk("R7 current address data", v, exp_mem[exp_ctr]);
      exp_ctr = exp_ctr + 8'd1;
      bus_stop();
    end

    // R8: random reads over spread addresses
    for (int r = 0; r < 16; r++) begin
      a = 8'(r * 17 + 3);
      seek_read(a);
      recv_byte(v, 1'b0);
      chk("R8 random read data", v, exp_mem[a]);
      bus_stop();
    end

    // R9: sequential read across the top of the space
    seek_read(8'hFD);
    for (int j = 0; j < 6; j++) begin
      recv_byte(v, j != 5);
      chk("R9 sequential wrap data", v, exp_mem[8'(8'hFD + j)]);
    end
    // R10: after the master's non-acknowledge the line stays released
    recv_byte(v, 1'b0);
    chk("R10 released after nack", v, 8'hFF);
    bus_stop();

    // R7: counter continues after the sequential read
    bus_start();
    send_byte(hdr(3'd5, 1'b1), k);
    recv_byte(v, 1'b0);
    chk("R7 counter after sequential", v, exp_mem[8'h03]);
    bus_stop();

    // R9: whole-space sequential read
    seek_read(8'h00);
    for (int j = 0; j < 256; j++) begin
      recv_byte(v, j != 255);
      chk("R9 full sequential data", v, exp_mem[j]);
    end
    bus_stop();

    // R11 monitor result; R12 back-pressure is exercised by the stalling memory
    chk("R11 pull only while SCL low", mon_bad, 0);
    chk("R12 no request left pending", {wr_valid, rd_valid}, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule